// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block connects a simple synchronous request port to an external asynchronous static RAM of 32K words by 8 bits. A client presents a request with valid, a write flag, an address and write data. The controller accepts it while ready is high. It then drives the memory's active-low chip select, output enable and write enable, the address bus and a tri-state data bus through a fixed sequence of clock cycles. When the access is finished it pulses done, and for a read it presents the captured data.

Each timing interval of the memory is counted down in clock cycles, and each count is set by a parameter: address access, minimum write pulse, write-to-high-Z, data setup and write recovery. A parameter selects whether output enable stays low through a write. When it does, the write pulse is stretched to cover the time the memory needs to release the bus plus the data setup time, and the controller does not drive the bus until that release time has passed. Between requests, chip select is held high so that the memory stays in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, chip select, write enable and output enable are all high (inactive), the data bus is released, done is low and ready is high.
- R2: Whenever no access is in progress, chip select is high and ready is high. While chip select is low, ready is low and no new request is accepted.
- R3: A read holds chip select low with output enable high for one cycle. It then holds output enable low with write enable high for exactly T_ACC cycles, and captures the data bus on the last of those cycles.
- R4: done is high for exactly one cycle. For a read it is high in the cycle T_ACC+2 clock edges after the accepting edge, with the read data valid. For a write it is high in the cycle P+T_WR+2 edges after the accepting edge.
- R5: A write holds write enable low for exactly P cycles, where P is max(T_WP, T_WHZ+T_DS) when output enable stays low through writes (OE_IN_WRITE=1) and T_WP otherwise. The memory then stores the request's data at the request's address.
- R6: The address bus changes only when a request is accepted, so it is stable for as long as chip select and write enable are both low.
- R7: The controller drives the data bus only while write enable is low or during write recovery. When OE_IN_WRITE=1 it waits T_WHZ pulse cycles before driving. It never drives while the memory may be driving, and the bus carries the write data at the instant write enable rises.
- R8: Before output enable falls for a read, the data bus has been released for at least one cycle.
- R9: A write ends with write enable rising while chip select is still low. Chip select then stays low for T_WR recovery cycles before it returns high and the next access may start.
- R10: The read data output keeps the last read's value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Captured read data, held until the next read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory data bus, tri-state |

## Verification
The bench measures the width of each write-enable pulse against the stretched value. A controller that ignored the output-enable rule would leave pulses of T_WP cycles, and the memory could latch data while its own drivers were still on the bus. It counts the recovery cycles after write enable rises, and it runs reads directly after writes and writes directly after reads. A controller with no turnaround cycle, or one that ended a write on chip select, would show a missing or shortened phase, or a wrong value read back. Writes placed between reads show whether the read data register is disturbed. Accesses to the lowest and highest addresses and all-zero and all-one data catch a truncated address bus or data path.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SET,
      ST_RD_ACC,
      ST_WR_SET,
      ST_WR_PULSE,
      ST_WR_REC
   } sram_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] remain,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign remain = cnt_q;
   assign zero   = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   logic [DATA_W-1:0] rdata_q;

   assign dq = drive_en ? wdata : {DATA_W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (capture)
         rdata_q <= dq;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int T_ACC       = 3,
   parameter int T_WP        = 2,
   parameter int T_WHZ       = 2,
   parameter int T_DS        = 2,
   parameter int T_WR        = 1,
   parameter bit OE_IN_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq
);

   // Write pulse length: stretched when the memory's outputs must first turn off
   localparam int PULSE = OE_IN_WRITE ? max2(T_WP, T_WHZ + T_DS) : T_WP;
   localparam int MAXC  = max2(max2(T_ACC, PULSE), T_WR);
   localparam int CNT_W = $clog2(MAXC + 1);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: widths must be positive");
   end
   if (T_ACC < 1 || T_WP < 1 || T_DS < 1 || T_WR < 1 || T_WHZ < 0) begin : g_bad_timing
      $error("sram_async_ctrl: wait counts out of range");
   end

   sram_state_e       state_q;
   sram_state_e       state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic [CNT_W-1:0]  tmr_remain;
   logic              tmr_zero;
   logic              data_phase;
   logic              dq_drive;
   logic              capture;
   logic              accept;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   // Next-state logic
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SET : ST_RD_SET;
         ST_RD_SET:   state_d = ST_RD_ACC;
         ST_RD_ACC:   if (tmr_zero) state_d = ST_IDLE;
         ST_WR_SET:   state_d = ST_WR_PULSE;
         ST_WR_PULSE: if (tmr_zero) state_d = ST_WR_REC;
         ST_WR_REC:   if (tmr_zero) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   // Interval timer loads
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_RD_SET: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_ACC - 1);
         end
         ST_WR_SET: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PULSE - 1);
         end
         ST_WR_PULSE: begin
            tmr_load = tmr_zero;
            tmr_val  = CNT_W'(T_WR - 1);
         end
         default: ;
      endcase
   end

   sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .remain   (tmr_remain),
      .zero     (tmr_zero)
   );

   // Request capture and completion pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         done_q <= ((state_q == ST_RD_ACC) || (state_q == ST_WR_REC)) && tmr_zero;
      end
   end

   // Output-enable policy and data phase inside the write pulse
   logic oe_in_wr;
   if (OE_IN_WRITE) begin : g_oe_held
      assign oe_in_wr   = (state_q == ST_WR_SET) || (state_q == ST_WR_PULSE);
      assign data_phase = (tmr_remain <= CNT_W'(PULSE - 1 - T_WHZ));
   end else begin : g_oe_off
      assign oe_in_wr   = 1'b0;
      assign data_phase = 1'b1;
   end

   assign mem_cs_n = (state_q == ST_IDLE);
   assign mem_we_n = (state_q != ST_WR_PULSE);
   assign mem_oe_n = !((state_q == ST_RD_ACC) || oe_in_wr);
   assign mem_addr = addr_q;

   assign dq_drive = ((state_q == ST_WR_PULSE) && data_phase) || (state_q == ST_WR_REC);
   assign capture  = (state_q == ST_RD_ACC) && tmr_zero;

   sram_dq_port #(.DATA_W(DATA_W)) i_dq (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_en (dq_drive),
      .wdata    (wdata_q),
      .capture  (capture),
      .rdata    (rsp_rdata),
      .dq       (mem_dq)
   );

   assign rsp_done = done_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int PULSE  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              dq_drive
);

   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (!mem_we_n)
         low_cnt <= low_cnt + 16'd1;
      else
         low_cnt <= '0;
   end

   // R2
   standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_cs_n);

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R5
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_cnt == 16'(PULSE)));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr));

   // R7
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> !(!mem_cs_n && !mem_oe_n && mem_we_n));

   // R7
   drive_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> !mem_cs_n);

   // R8
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_oe_n) && mem_we_n) |-> $past(!dq_drive));

   // R9
   we_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_cs_n);

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .PULSE  (PULSE)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .mem_cs_n  (mem_cs_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_addr  (mem_addr),
   .dq_drive  (dq_drive)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 15;
   localparam int DW    = 8;
   localparam int T_ACC = 3;
   localparam int T_WP  = 2;
   localparam int T_WHZ = 2;
   localparam int T_DS  = 2;
   localparam int T_WR  = 1;
   localparam int PW    = (T_WHZ + T_DS > T_WP) ? (T_WHZ + T_DS) : T_WP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_done;
   logic          mem_cs_n, mem_oe_n, mem_we_n;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_WP(T_WP),
      .T_WHZ(T_WHZ), .T_DS(T_DS), .T_WR(T_WR), .OE_IN_WRITE(1'b1)
   ) i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_cs_n(mem_cs_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
   );

   // Behavioural memory: 256 cells indexed by the low address byte, full address kept as tag
   logic [DW-1:0] mdata [0:255];
   logic [AW-1:0] mtag  [0:255];
   logic [DW-1:0] shadow [0:255];
   logic [DW-1:0] model_q;

   always_comb model_q = mdata[mem_addr[7:0]];
   assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? model_q : {DW{1'bz}};

   always @(posedge mem_we_n) begin
      if (!mem_cs_n) begin
         mdata[mem_addr[7:0]] = mem_dq;
         mtag[mem_addr[7:0]]  = mem_addr;
      end
   end

   typedef struct {
      bit          wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      int          due;
   } item_t;
   item_t exp_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic issue(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] data);
      item_t it;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      req_wdata = data;
      it.wr   = wr;
      it.addr = addr;
      it.data = wr ? data : shadow[addr[7:0]];
      it.due  = cyc + (wr ? (2 + PW + T_WR) : (2 + T_ACC));
      if (wr) shadow[addr[7:0]] = data;
      exp_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      // R2: a busy controller is not ready
      check(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
   endtask

   // Monitor / scoreboard
   int          low_cnt = 0;
   int          oe_cnt  = 0;
   int          rec_cnt = 0;
   bit          in_rec  = 1'b0;
   bit          prev_we = 1'b1;
   bit          prev_oe = 1'b1;
   bit          prev_cs = 1'b1;
   logic [AW-1:0] wr_addr0 = '0;
   logic [DW-1:0] last_rd = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ready)
            check(mem_cs_n == 1'b1, "R2 standby", int'(mem_cs_n), 1);
         if (!mem_we_n) begin
            if (prev_we) wr_addr0 = mem_addr;
            low_cnt++;
            check(mem_addr == wr_addr0, "R6 addr", int'(mem_addr), int'(wr_addr0));
         end
         if (mem_we_n && !prev_we) begin
            check(low_cnt == PW, "R5 pulse", low_cnt, PW);
            check(!mem_cs_n, "R9 we first", int'(mem_cs_n), 0);
            if (exp_q.size() > 0)
               check(mem_dq === exp_q[0].data, "R7 bus", int'(mem_dq), int'(exp_q[0].data));
            low_cnt = 0;
            in_rec  = 1'b1;
            rec_cnt = 0;
         end
         if (in_rec && !mem_cs_n && mem_we_n) rec_cnt++;
         if (in_rec && mem_cs_n) begin
            check(rec_cnt == T_WR, "R9 recovery", rec_cnt, T_WR);
            in_rec = 1'b0;
         end
         if (!mem_oe_n && mem_we_n && exp_q.size() > 0 && !exp_q[0].wr) begin
            if (prev_oe)
               check(!prev_cs && prev_we, "R8 turnaround", int'(prev_cs), 0);
            oe_cnt++;
         end
         if (rsp_done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(cyc == it.due, "R4 latency", cyc, it.due);
               if (it.wr) begin
                  check(mdata[it.addr[7:0]] == it.data, "R5 stored", int'(mdata[it.addr[7:0]]), int'(it.data));
                  check(mtag[it.addr[7:0]] == it.addr, "R6 address", int'(mtag[it.addr[7:0]]), int'(it.addr));
                  check(rsp_rdata == last_rd, "R10 hold", int'(rsp_rdata), int'(last_rd));
               end else begin
                  check(rsp_rdata == it.data, "R3 data", int'(rsp_rdata), int'(it.data));
                  check(oe_cnt == T_ACC, "R3 access", oe_cnt, T_ACC);
                  last_rd = it.data;
               end
               oe_cnt = 0;
            end
         end
         if (prev_done_q) check(!rsp_done, "R4 single", int'(rsp_done), 0);
         prev_done_q = rsp_done;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
      prev_cs = mem_cs_n;
   end
   bit prev_done_q = 1'b0;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mdata[i]  = DW'(i ^ 8'h5A);
         shadow[i] = DW'(i ^ 8'h5A);
         mtag[i]   = '0;
      end
      repeat (3) @(negedge clk);
      // R1: outputs inactive during reset
      check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
      check(rsp_done == 1'b0, "R1 done", int'(rsp_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && mem_cs_n && mem_we_n && mem_oe_n, "R1 after reset", int'(req_ready), 1);
      check(mem_dq === 8'hzz, "R1 bus", int'(mem_dq), 0);

      issue(1'b0, 15'h0012, 8'h00);          // read initial content
      issue(1'b1, 15'h0000, 8'hFF);          // lowest address, all ones
      issue(1'b1, 15'h7FFF, 8'h00);          // highest address, all zeros
      issue(1'b0, 15'h0000, 8'h00);          // read right after write
      issue(1'b0, 15'h7FFF, 8'h00);
      issue(1'b1, 15'h1234, 8'hA5);          // write right after read
      issue(1'b1, 15'h4321, 8'h3C);
      issue(1'b0, 15'h1234, 8'h00);
      repeat (5) @(negedge clk);              // idle gap: standby
      issue(1'b0, 15'h4321, 8'h00);
      for (int k = 0; k < 8; k++) issue(1'b1, AW'(15'h2200 + k * 15'h0101), DW'(k * 37));
      for (int k = 0; k < 8; k++) issue(1'b0, AW'(15'h2200 + k * 15'h0101), 8'h00);
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R4 all done", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule